// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Receiver

This block is a receive-only target on a two-wire serial bus (I2C). It oversamples the clock and data wires with a fast system clock, recognises bus START and STOP conditions, and compares the first byte after each START against its own 7-bit address plus a write direction bit. One bit of that address comes from a strap input. On a match it acknowledges and then accepts data bytes until the next STOP or START, acknowledging every byte. Each complete byte appears on a parallel output together with a single-cycle valid pulse.

The data wire is driven only as an open-drain pull-down: the block raises an enable output whenever the wire must be held low, and the pad or board pull-up supplies the high level. A mode input keeps the whole interface quiet unless it is low. Read transfers, clock stretching, extended addressing and general call are not handled.

Top module: `i2c_wr_sink`

## Requirements
- R1: While rst_ni is low, sda_oe_o and byte_vld_o are 0.
- R2: The address byte, sent most significant bit first, matches only when it equals binary 1111_10X0, where X is the level of addr_sel_i. On a match the block holds SDA low (sda_oe_o = 1) through the 9th SCL pulse.
- R3: A non-matching address byte, including one whose last (direction) bit is 1, is not acknowledged; all later bytes are ignored (no acknowledge, no byte_vld_o) until the next START.
- R4: After an acknowledged address, every data byte is taken in most significant bit first, sampled on SCL rising edges, and acknowledged on its 9th SCL pulse; any number of bytes may follow.
- R5: Each received data byte is presented on byte_o with byte_vld_o high for exactly one clk_i cycle, shortly after its 8th bit is sampled.
- R6: A START (SDA falling while SCL is high) begins a new address phase; a START in the middle of a data byte discards the partial byte, which is never presented.
- R7: A STOP (SDA rising while SCL is high) returns the block to idle; bytes clocked afterwards without a new START are neither acknowledged nor presented.
- R8: While mode_sel_i is high, sda_oe_o stays 0 and byte_vld_o never pulses.
- R9: sda_oe_o only changes while SCL is low, so the block's own drive never forms a START or STOP.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock wire, asynchronous |
| sda_i | input | 1 | Bus data wire as seen at the pad, asynchronous |
| addr_sel_i | input | 1 | Strap that sets address bit X |
| mode_sel_i | input | 1 | Interface enabled only when low |
| sda_oe_o | output | 1 | 1 = pull the data wire low |
| byte_o | output | 8 | Last received data byte |
| byte_vld_o | output | 1 | One-cycle strobe for byte_o |

## Verification
The hardest situations to reach are the ones that depend on wired-AND behaviour of the data line and on conditions occurring mid-frame: an acknowledge is only visible on the resolved wire, and a repeated START must land after a few bits of a data byte. The bench models the open-drain line as the master's drive ANDed with the inverse of sda_oe_o, samples the acknowledge in the middle of the 9th high phase, and has a bus task that raises SDA while SCL is low and then pulls it low with SCL high after four data bits, so the partial byte must vanish from the scoreboard.

// File: rtl/i2c_wr_sink_pkg.sv
package i2c_wr_sink_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2c_wr_sink_sync.sv
module i2c_wr_sink_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // Idle bus level is high, so reset to ones.
  for (genvar w = 0; w < WIDTH; w++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else if (STAGES == 1) chain_q[0] <= d_i[w];
      else chain_q <= {chain_q[STAGES-2:0], d_i[w]};
    end
    assign q_o[w] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_wr_sink_cond.sv
module i2c_wr_sink_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SCL must be high on both samples so that a coincident SCL edge is not a condition.
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_wr_sink_fsm.sv
module i2c_wr_sink_fsm
  import i2c_wr_sink_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b111110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              addr_sel_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic [BYTE_W-1:0] shift_nxt;
  logic              addr_hit;

  assign shift_nxt = {shift_q[BYTE_W-2:0], sda_s_i};
  assign addr_hit  = (shift_nxt == {ADDR_HI, addr_sel_i, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      sda_oe_o   <= 1'b0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else if (!en_i) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sda_oe_o   <= 1'b0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise_i) begin
            shift_q <= shift_nxt;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) state_q <= addr_hit ? ST_ACK : ST_SKIP;
          end
          ST_DATA: if (scl_rise_i) begin
            shift_q <= shift_nxt;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              byte_o     <= shift_nxt;
              byte_vld_o <= 1'b1;
              state_q    <= ST_ACK;
            end
          end
          // First fall after bit 8 pulls low, next fall (end of pulse 9) releases.
          ST_ACK: if (scl_fall_i) begin
            if (!sda_oe_o) begin
              sda_oe_o <= 1'b1;
            end else begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              state_q  <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wr_sink.sv
module i2c_wr_sink
  import i2c_wr_sink_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [5:0]  ADDR_HI     = 6'b111110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  input  logic              mode_sel_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o
);
  logic [1:0] bus_s;
  logic scl_rise, scl_fall, start_c, stop_c;

  i2c_wr_sink_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (bus_s)
  );

  i2c_wr_sink_cond i_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (bus_s[1]),
    .sda_s_i    (bus_s[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_wr_sink_fsm #(.ADDR_HI(ADDR_HI)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (~mode_sel_i),
    .addr_sel_i (addr_sel_i),
    .sda_s_i    (bus_s[0]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .sda_oe_o   (sda_oe_o),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o)
  );
endmodule

// File: rtl/i2c_wr_sink_chk.sv
module i2c_wr_sink_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic mode_sel_i,
  input logic sda_oe_o,
  input logic byte_vld_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!sda_oe_o && !byte_vld_o));

  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  assert_disabled_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i && $past(mode_sel_i)) |-> (!sda_oe_o && !byte_vld_o));

  assert_drive_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !mode_sel_i && !$past(mode_sel_i)) |-> !scl_i);
endmodule

bind i2c_wr_sink i2c_wr_sink_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .mode_sel_i (mode_sel_i),
  .sda_oe_o   (sda_oe_o),
  .byte_vld_o (byte_vld_o)
);

// File: tb/test_i2c_wr_sink.sv
`timescale 1ns/1ps
module test_i2c_wr_sink;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, mode_sel = 1'b0;
  logic sda_oe, byte_vld;
  logic [7:0] byte_d;
  wire  sda_bus = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  i2c_wr_sink i_i2c_wr_sink (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .addr_sel_i (addr_sel),
    .mode_sel_i (mode_sel),
    .sda_oe_o   (sda_oe),
    .byte_o     (byte_d),
    .byte_vld_o (byte_vld)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Monitor: every strobe must match the head of the scoreboard queue.
  always @(negedge clk) begin
    if (rst_ni && byte_vld) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected byte", byte_d, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(byte_d == e, "R4 byte value", byte_d, e);
      end
    end
  end

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wq(Q);
    sda_m = 0; wq(Q);
    scl_m = 0; wq(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1; wq(Q);
    scl_m = 1; wq(Q);
    sda_m = 0; wq(Q);
    scl_m = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q);
    scl_m = 1; wq(Q);
    sda_m = 1; wq(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wq(Q);
    scl_m = 1; wq(2*Q);
    scl_m = 0; wq(Q);
  endtask

  task automatic get_ack(output bit ack);
    sda_m = 1; wq(Q);
    scl_m = 1; wq(Q);
    ack = !sda_bus;
    wq(Q);
    scl_m = 0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    get_ack(ack);
  endtask

  // Driver: data bytes that should be accepted go into the queue first.
  task automatic send_data(input logic [7:0] b, input bit accepted, input string tag);
    bit a;
    if (accepted) exp_q.push_back(b);
    send_byte(b, a);
    check(a == accepted, tag, a, accepted);
  endtask

  task automatic drain(input string tag);
    wq(10);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    bit a;
    wq(3);
    check(!sda_oe && !byte_vld, "R1 reset outputs", {sda_oe, byte_vld}, 0);
    rst_ni = 1; wq(5);

    // R2: strap low, address F8, then stream several bytes
    bus_start();
    send_byte(8'hF8, a); check(a, "R2 ack addr X=0", a, 1);
    send_data(8'hA5, 1, "R4 ack byte0");
    send_data(8'h00, 1, "R4 ack byte1");
    send_data(8'hFF, 1, "R4 ack byte2");
    send_data(8'h3C, 1, "R4 ack byte3");
    bus_stop();
    drain("R5 all bytes strobed");

    // R2: strap high, address FA
    addr_sel = 1; wq(5);
    bus_start();
    send_byte(8'hF8, a); check(!a, "R2 old addr rejected X=1", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hFA, a); check(a, "R2 ack addr X=1", a, 1);
    send_data(8'h81, 1, "R4 ack byte X=1");
    bus_stop();
    drain("R5 byte X=1");
    addr_sel = 0; wq(5);

    // R3: mismatch and read bit
    bus_start();
    send_byte(8'hF0, a); check(!a, "R3 mismatch nack", a, 0);
    send_data(8'h55, 0, "R3 ignored after mismatch");
    bus_stop();
    bus_start();
    send_byte(8'hF9, a); check(!a, "R3 read bit nack", a, 0);
    send_data(8'h12, 0, "R3 ignored after read bit");
    bus_stop();
    drain("R3 no strobes");

    // R6: repeated START mid-byte drops partial data
    bus_start();
    send_byte(8'hF8, a); check(a, "R6 ack before abort", a, 1);
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    bus_rstart();
    send_byte(8'hF8, a); check(a, "R6 ack after restart", a, 1);
    send_data(8'h6E, 1, "R6 byte after restart");
    bus_stop();
    drain("R6 partial discarded");

    // R7: bytes without START after STOP are ignored
    bus_start();
    send_byte(8'hF8, a); check(a, "R7 ack addr", a, 1);
    bus_stop();
    scl_m = 0; wq(Q);
    send_data(8'hF8, 0, "R7 no ack after stop");
    send_data(8'h99, 0, "R7 no byte after stop");
    scl_m = 1; wq(Q);
    drain("R7 no strobes");

    // R8: mode select high silences the interface
    mode_sel = 1; wq(5);
    bus_start();
    send_byte(8'hF8, a); check(!a, "R8 no ack when disabled", a, 0);
    send_data(8'h77, 0, "R8 no byte when disabled");
    bus_stop();
    drain("R8 no strobes");
    mode_sel = 0; wq(5);
    bus_start();
    send_byte(8'hF8, a); check(a, "R8 ack after re-enable", a, 1);
    send_data(8'hC3, 1, "R8 byte after re-enable");
    bus_stop();
    drain("R8 re-enabled strobe");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wq(200000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule